// File: doc/BRIEF.md
# Frame CRC-6 Generator

This block computes a six-bit cyclic redundancy check over the payload bits of each transmit frame and presents the result during the check-bit slot of the following frame. A frame assembler feeds the transmit stream one bit at a time, with a valid strobe. Each accepted bit carries three qualifiers: sync, stuff and check-slot. The assembler also pulses a frame-start marker on the first cycle of every frame. Bits marked by any qualifier, and cycles with the strobe low, do not enter the calculation.

At each frame start the block latches the remainder of the frame that just ended and clears its running remainder. It then shifts the six latched bits out serially, one per check-slot bit of the new frame, starting with the highest-order coefficient. A one-shot request can be raised at any time. It is taken at the next frame start and inverts all six check bits of that frame only. A length monitor flags any frame whose count of included bits differs from the expected payload size. Frame layout, sync generation and multiplexing stay with the assembler.

Top module: `crc6_frame_gen`

## Requirements
- R1: The check word for a frame is the remainder of the included bits, taken in arrival order with the first bit as the highest power and multiplied by x^6, divided modulo 2 by x^6 + x + 1. Word bit 5 holds the x^5 coefficient and bit 0 holds the x^0 coefficient.
- R2: Bits accepted with the sync qualifier high have no effect on the check word.
- R3: Bits accepted with the stuff qualifier high have no effect on the check word.
- R4: Bits with the check-slot qualifier high, and cycles with the valid strobe low, have no effect on the check word.
- R5: The check word of frame N appears on `crc_word` from the clock edge that ends the frame-start cycle of frame N+1, and it holds until the next frame start. After reset, and for the first frame, the word is zero.
- R6: During frame N+1, the k-th check-slot bit (k = 0..5) drives `crc_bit` with word bit 5-k, so the x^5 coefficient goes out first.
- R7: A pulse on `inject_req` inverts all six serial check bits of the next frame that starts. `inj_active` is high for that frame.
- R8: An injection applies to one frame only. The frame after an injected frame carries uninverted check bits unless a new request arrives.
- R9: From each frame start other than the first after reset, `len_err` is high for the whole frame exactly when the previous frame held a count of included bits other than PAYLOAD_BITS (4682 by default).
- R10: After reset, `crc_word` is zero and `len_err` and `inj_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle marker on the first cycle of a frame; never coincides with a check-slot bit |
| bit_valid | input | 1 | A stream bit is present this cycle |
| bit_data | input | 1 | Stream bit value |
| is_sync | input | 1 | Current bit belongs to the sync word |
| is_stuff | input | 1 | Current bit is a stuff bit |
| is_crc | input | 1 | Current bit is a check-bit slot |
| inject_req | input | 1 | Request to corrupt the check bits of the next frame |
| crc_bit | output | 1 | Serial check bit for the current check slot |
| crc_word | output | 6 | Latched check word of the previous frame |
| inj_active | output | 1 | The check bits of the current frame are being inverted |
| len_err | output | 1 | The previous frame held a wrong number of included bits |

## Verification
The bench puts sync, check-slot and stuff bits and idle strobe-low cycles, most carrying a one, inside every frame. A design that let any of them into the division produces a word that differs from the reference long division. It checks the serial order bit by bit, so an order reversed between the x^5 and x^0 coefficients fails at once. It places an injection request mid-frame and checks both the inverted frame and the clean frame after it, which catches a request that is taken too early or never cleared. A frame one bit short checks that the length flag rises for exactly the following frame and drops again after it.

// File: rtl/crc6_frame_pkg.sv
// Shared types and the serial division step for the frame CRC-6 generator.
// Assumes the generator x^6 + x + 1. GEN_LOW holds its terms below x^6.
package crc6_frame_pkg;
    localparam int CRC_W = 6;
    typedef logic [CRC_W-1:0] crc_t;
    localparam crc_t GEN_LOW = 6'b000011;

    // One bit of modulo-2 division of (message * x^CRC_W) by the generator.
    function automatic crc_t crc_step(input crc_t rem, input logic din);
        logic fb;
        fb = din ^ rem[CRC_W-1];
        return {rem[CRC_W-2:0], 1'b0} ^ (fb ? GEN_LOW : '0);
    endfunction
endpackage

// File: rtl/crc6_remainder.sv
// Running remainder over the included bits of the current frame.
// Assumes: take is high only for included payload bits. A bit taken in the
// frame-start cycle belongs to the new frame.
module crc6_remainder
    import crc6_frame_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic take,
    input  logic din,
    output crc_t rem_q
);
    // Restart the division at frame start and fold in each taken bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= '0;
        else if (frame_start)
            rem_q <= take ? crc_step('0, din) : '0;
        else if (take)
            rem_q <= crc_step(rem_q, din);
    end

    // R4: excluded or idle cycles leave the remainder untouched.
    a_r4_rem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !take) |=> $stable(rem_q));

    // R1: a frame start with no taken bit leaves a cleared remainder.
    a_r1_rem_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !take) |=> (rem_q == '0));
endmodule

// File: rtl/crc6_len_mon.sv
// Counts the included bits of each frame and flags a frame of wrong length.
// The flag is updated at each frame start and holds for that whole frame.
// No flag is raised at the first frame start after reset.
module crc6_len_mon #(
    parameter int PAYLOAD_BITS = 4682
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic take,
    output logic len_err
);
    localparam int CNT_W = $clog2(PAYLOAD_BITS + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_EXP = CNT_W'(PAYLOAD_BITS);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    // Saturating count of included bits, restarted at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (frame_start)
            cnt_q <= take ? CNT_W'(1) : '0;
        else if (take && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    // Judge the length of the frame that just ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_err <= 1'b0;
            seen_q  <= 1'b0;
        end else if (frame_start) begin
            len_err <= seen_q && (cnt_q != CNT_EXP);
            seen_q  <= 1'b1;
        end
    end

    // R9: the flag changes only at a frame start.
    a_r9_len_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(len_err));
endmodule

// File: rtl/crc6_tx_ser.sv
// Holds the previous frame's check word and serialises it over the check
// slots of the current frame, high coefficient first, with optional inversion.
// Assumes: at most CRC_W slot bits per frame, none in the frame-start cycle.
module crc6_tx_ser
    import crc6_frame_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic slot,
    input  logic inject_req,
    input  crc_t rem_in,
    output crc_t word_q,
    output logic inj_q,
    output logic ser_bit
);
    localparam int IDX_W = $clog2(CRC_W + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(CRC_W);

    logic [IDX_W-1:0] idx_q;
    logic             pend_q;

    // Latch the finished remainder for transmission at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (frame_start)
            word_q <= rem_in;
    end

    // Arm an injection request, then apply it to exactly one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            inj_q  <= 1'b0;
        end else if (frame_start) begin
            inj_q  <= pend_q | inject_req;
            pend_q <= 1'b0;
        end else if (inject_req) begin
            pend_q <= 1'b1;
        end
    end

    // Step through the check slots of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start)
            idx_q <= '0;
        else if (slot && idx_q != IDX_END)
            idx_q <= idx_q + 1'b1;
    end

    // Select the word bit for the current slot, highest coefficient first.
    always_comb begin
        ser_bit = 1'b0;
        for (int k = 0; k < CRC_W; k++)
            if (idx_q == IDX_W'(k))
                ser_bit = word_q[CRC_W-1-k] ^ inj_q;
    end

    // R5: the transmitted word changes only at a frame start.
    a_r5_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(word_q));

    // R8: the injection state changes only at a frame start.
    a_r8_inj_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(inj_q));

    // R7: a request at frame start turns injection on for the new frame.
    a_r7_inj_take: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && inject_req) |=> inj_q);
endmodule

// File: rtl/crc6_frame_gen.sv
// Frame CRC-6 generator top. It qualifies stream bits, keeps the running
// remainder, serialises the previous frame's word into the current frame's
// check slots and checks the frame length.
// Assumes: frame_start is one cycle long and never marks a check-slot bit.
module crc6_frame_gen
    import crc6_frame_pkg::*;
#(
    parameter int PAYLOAD_BITS = 4682
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic             is_sync,
    input  logic             is_stuff,
    input  logic             is_crc,
    input  logic             inject_req,
    output logic             crc_bit,
    output logic [CRC_W-1:0] crc_word,
    output logic             inj_active,
    output logic             len_err
);
    logic take;
    logic slot;
    crc_t rem;
    crc_t word;

    // Decide which stream bits enter the division and which are check slots.
    always_comb begin
        take = bit_valid && !is_sync && !is_stuff && !is_crc;
        slot = bit_valid && is_crc;
    end

    crc6_remainder u_rem (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .take        (take),
        .din         (bit_data),
        .rem_q       (rem)
    );

    crc6_len_mon #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .take        (take),
        .len_err     (len_err)
    );

    crc6_tx_ser u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .slot        (slot),
        .inject_req  (inject_req),
        .rem_in      (rem),
        .word_q      (word),
        .inj_q       (inj_active),
        .ser_bit     (crc_bit)
    );

    // Drive the parallel view of the held word.
    always_comb crc_word = word;

    // R5: the word held after a frame start is the remainder at its end.
    a_r5_word_latch: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (crc_word == $past(rem)));
endmodule

// File: tb/crc6_frame_gen_test.sv
module crc6_frame_gen_test;
    localparam int PAY = 4682;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
    logic       is_sync = 1'b0, is_stuff = 1'b0, is_crc = 1'b0, inject_req = 1'b0;
    logic       crc_bit, inj_active, len_err;
    logic [5:0] crc_word;

    int checks = 0, fails = 0, cycles = 0;
    bit exp_q[$];
    bit mon_en = 1'b0;
    bit payload[PAY+8];
    logic [5:0] prev_word = '0;
    bit cur_inj = 1'b0, first = 1'b1;
    int prev_len = PAY;
    int unsigned seed = 32'h1234_5677;

    crc6_frame_gen uut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference: long division of (bits * x^6) by x^6 + x + 1 (R1).
    function automatic logic [5:0] ref_crc(input int n);
        bit w[PAY+16];
        logic [5:0] r;
        for (int i = 0; i < n + 6; i++) w[i] = (i < n) ? payload[i] : 1'b0;
        for (int i = 0; i < n; i++)
            if (w[i]) begin
                w[i] ^= 1'b1; w[i+5] ^= 1'b1; w[i+6] ^= 1'b1;
            end
        for (int k = 0; k < 6; k++) r[5-k] = w[n+k];
        return r;
    endfunction

    function automatic bit rnd();
        seed = seed * 1103515245 + 12345;
        return seed[16];
    endfunction

    task automatic put(input bit fs, input bit v, input bit d, input bit s, input bit st, input bit c);
        @(posedge clk); #1;
        frame_start = fs; bit_valid = v; bit_data = d;
        is_sync = s; is_stuff = st; is_crc = c;
    endtask

    // Monitor: compares each serial check bit with the scoreboard (R6, R7, R8).
    always @(negedge clk) begin
        if (rst_n && mon_en && bit_valid && is_crc) begin
            if (exp_q.size() == 0) check("R6 queue", 8'(crc_bit), 8'hEE);
            else check("R6/R7/R8 serial bit", 8'(crc_bit), 8'(exp_q.pop_front()));
        end
    end

    // Drives one frame of npay included bits; stf adds stuff bits, inj_next requests injection.
    task automatic drive_frame(input int npay, input bit stf, input bit inj_next);
        logic [5:0] w;
        for (int i = 0; i < npay; i++) payload[i] = rnd();
        mon_en = !first;
        if (!first) begin
            w = prev_word ^ (cur_inj ? 6'h3F : 6'h00);
            for (int k = 5; k >= 0; k--) exp_q.push_back(w[k]);
        end
        for (int i = 0; i < 14; i++) put(i == 0, 1, (i % 3) != 2, 1, 0, 0);  // R2 sync
        @(negedge clk);
        check("R5 crc_word", 8'(crc_word), 8'(first ? 6'h00 : prev_word));
        check("R9 len_err", 8'(len_err), 8'((!first && prev_len != PAY) ? 1 : 0));
        check("R7/R8 inj_active", 8'(inj_active), 8'(cur_inj));
        for (int i = 0; i < 6; i++) put(0, 1, 1, 0, 0, 1);                   // R4 slots
        for (int i = 0; i < npay; i++) begin
            if (i % 97 == 50) put(0, 0, 1, 0, 0, 0);                          // R4 idle
            if (stf && i == 1000)
                for (int k = 0; k < 4; k++) put(0, 1, 1, 0, 1, 0);           // R3 stuff
            put(0, 1, payload[i], 0, 0, 0);
            inject_req = inj_next && (i == 2000);
        end
        put(0, 0, 0, 0, 0, 0);
        inject_req = 1'b0;
        if (!first && exp_q.size() != 0) check("R6 unused bits", 8'(exp_q.size()), 8'h00);
        exp_q.delete();
        prev_word = ref_crc(npay);
        prev_len = npay;
        cur_inj = inj_next;
        first = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 crc_word", 8'(crc_word), 8'h00);
        check("R10 len_err", 8'(len_err), 8'h00);
        check("R10 inj_active", 8'(inj_active), 8'h00);
        @(posedge clk); #1 rst_n = 1'b1;
        drive_frame(PAY, 1, 0);       // first frame, R2/R3/R4 exclusions
        drive_frame(PAY, 0, 1);       // R1 word of frame 0, request injection
        drive_frame(PAY, 1, 0);       // R7 inverted bits
        drive_frame(PAY - 1, 0, 0);   // R8 clean again, short frame
        drive_frame(PAY, 0, 0);       // R9 flag high
        drive_frame(PAY, 1, 0);       // R9 flag low again
        put(1, 0, 0, 0, 0, 0);
        put(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R1 final crc_word", 8'(crc_word), 8'(prev_word));
        check("R9 final len_err", 8'(len_err), 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule